// File: doc/BRIEF.md
# Burst Address Counter with Load

This block produces the address used by one port of a synchronous memory on every clock cycle. Each rising edge applies one of four actions to an internal address register: clear to zero, load the external address, keep the last address, or step to the next address. The address it selects drives the memory array combinationally in the same cycle, so the access that cycle goes to the new address with no dead cycle. Address bursts can then run from a single starting address without the host driving an address each cycle.

The three control inputs are active low and have a fixed priority: clear first, then load, then advance. While load is asserted the advance input has no effect. With all three deasserted the external address is ignored and the previous address is used again. The counter wraps from all ones to zero. The actions do not depend on any chip-enable or byte-select qualifiers, so the block has no such inputs. The address width is a parameter, 16 bits by default.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the stored address to 0. In the first cycle after reset, with all controls deasserted, `acc_addr` is 0.
- R2: When `clr_n` is 0, `acc_addr` is 0 in that cycle, whatever `ld_n`, `adv_n` and `ext_addr` are.
- R3: When `clr_n` is 1 and `ld_n` is 0, `acc_addr` equals `ext_addr` in that cycle, and `adv_n` has no effect.
- R4: When `clr_n`, `ld_n` and `adv_n` are all 1, `acc_addr` equals the address of the previous cycle, and `ext_addr` has no effect.
- R5: When `clr_n` and `ld_n` are 1 and `adv_n` is 0, `acc_addr` equals the previous cycle's address plus one.
- R6: An advance from the all-ones address gives address 0.
- R7: The address used in a cycle is the one stored for the next cycle. A clear followed by an advance gives 1. A load followed by a hold gives the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External start address |
| ld_n | input | 1 | Load external address, active low |
| adv_n | input | 1 | Advance to next address, active low |
| clr_n | input | 1 | Clear address to zero, active low |
| acc_addr | output | ADDR_W | Address used for this cycle's access |

## Verification
A fault in the stored address is not visible while clear or load is asserted. It shows at `acc_addr` in the first hold or advance cycle after the fault, because that output is built directly from the stored value. An error in the priority decode or the increment shows in the same cycle as the stimulus that exercises it. The bench therefore compares every cycle against an independent model and runs long hold and advance stretches after each clear and load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_ZERO = 2'd3
  } addr_act_e;
endpackage

// File: rtl/burst_act_dec.sv
module burst_act_dec
  import burst_addr_pkg::*;
(
  input  logic      ld_n,
  input  logic      adv_n,
  input  logic      clr_n,
  output addr_act_e act
);
  // Priority: clear, then load, then advance.
  always_comb begin
    if (!clr_n)      act = ACT_ZERO;
    else if (!ld_n)  act = ACT_LOAD;
    else if (!adv_n) act = ACT_STEP;
    else             act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_act_e         act,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] sel_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc_addr;
  assign inc_addr = cur_addr + ONE;

  always_comb begin
    unique case (act)
      ACT_ZERO: sel_addr = '0;
      ACT_LOAD: sel_addr = ext_addr;
      ACT_STEP: sel_addr = inc_addr;
      default:  sel_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ld_n,
  input  logic              adv_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] acc_addr
);
  addr_act_e         act;
  logic [ADDR_W-1:0] cur_addr;

  burst_act_dec u_dec (
    .ld_n  (ld_n),
    .adv_n (adv_n),
    .clr_n (clr_n),
    .act   (act)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .act      (act),
    .cur_addr (cur_addr),
    .ext_addr (ext_addr),
    .sel_addr (acc_addr)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (acc_addr),
    .q   (cur_addr)
  );

  // Marks cycles whose previous cycle was out of reset.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (acc_addr == '0));

  // R3
  load_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |-> (acc_addr == ext_addr));

  // R4
  hold_prev_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && clr_n && ld_n && adv_n) |-> (acc_addr == $past(acc_addr)));

  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && clr_n && ld_n && !adv_n)
      |-> (acc_addr == $past(acc_addr) + ADDR_W'(1)));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic         ld_n = 1'b1, adv_n = 1'b1, clr_n = 1'b1;
  logic [W-1:0] acc_addr;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .ld_n(ld_n),
    .adv_n(adv_n), .clr_n(clr_n), .acc_addr(acc_addr)
  );

  typedef struct { logic [W-1:0] addr; string req; } exp_t;
  exp_t exp_q[$];
  logic [W-1:0] model_q = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic step(input bit c, input bit l, input bit a,
                      input logic [W-1:0] e, input string req);
    logic [W-1:0] nx;
    exp_t it;
    @(negedge clk);
    clr_n = c; ld_n = l; adv_n = a; ext_addr = e;
    if (!c)      nx = '0;
    else if (!l) nx = e;
    else if (!a) nx = model_q + W'(1);
    else         nx = model_q;
    model_q = nx;
    it.addr = nx; it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: compares mid-cycle, after the driver has settled inputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (acc_addr !== it.addr) begin
          n_fail++;
          $display("FAIL %s: acc_addr=%h expected=%h", it.req, acc_addr, it.addr);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_q = '0;
    step(1, 1, 1, 16'hBEEF, "R1");       // reset state, ext ignored
    step(1, 1, 0, 16'h0000, "R5");       // 1
    step(1, 1, 0, 16'h1234, "R5");       // 2
    step(1, 0, 1, 16'h1230, "R3");       // load
    step(1, 1, 1, 16'h5555, "R7");       // hold keeps loaded
    step(1, 1, 1, 16'hAAAA, "R4");
    step(1, 0, 0, 16'h00F0, "R3");       // adv ignored under load
    for (int i = 0; i < 5; i++) step(1, 1, 0, 16'h9999, "R5");
    step(0, 0, 0, 16'h7777, "R2");       // clear wins
    step(1, 1, 0, 16'h7777, "R7");       // 1 after clear
    step(0, 1, 1, 16'h4444, "R2");
    step(1, 1, 1, 16'h4444, "R4");
    step(1, 0, 1, 16'hFFFE, "R3");
    step(1, 1, 0, 16'h0000, "R5");       // FFFF
    step(1, 1, 0, 16'h0000, "R6");       // wrap to 0
    step(1, 1, 0, 16'h0000, "R6");       // 1
    step(1, 0, 1, 16'hFFFF, "R3");
    step(1, 1, 0, 16'h1111, "R6");
    for (int i = 0; i < 20; i++)
      step(i % 7 != 3, i % 5 != 1, i % 2 == 0, W'(i * 4099), "R4");
    step(1, 1, 1, 16'h0000, "R4");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule